// File: doc/BRIEF.md
# Memory Ordering Issue Unit

This block sits between a processor's load/store stream and the memory system and decides, cycle by cycle, whether the next memory operation may be released. Requests arrive in program order with a kind and a tag over a ready/valid handshake. An accepted request is passed to memory in the same cycle. The block tracks how many issued operations are still outstanding by counting completion acknowledgements that return from memory.

A mode input picks one of two ordering disciplines. In strict mode every operation waits until nothing is outstanding, so the memory system never holds more than one operation. A read in strict mode is finished only when its response reports that the data it returned is visible to every processor. In relaxed mode ordinary reads and writes overlap up to a fixed limit. Synchronisation kinds then act as barriers: an acquire holds back later operations, a release waits for earlier ones, and a fence does both. The coherence protocol and the memory are outside the block; acknowledgements and the visibility flag are inputs.

Top module: `mo_issue_unit`

## Requirements
- R1: Operations leave in the order they were accepted. `mem_valid` equals `req_valid && req_ready`, and `mem_kind` and `mem_tag` carry the request unchanged in that cycle. Kind codes: 0 read, 1 write, 2 acquire, 3 release, 4 fence.
- R2: With `relaxed_mode` low, a request is accepted only when no operation is outstanding. After any issue, nothing further issues until that operation has completed.
- R3: With `relaxed_mode` low, an outstanding read is retired only by an acknowledgement with `cpl_vis` high. An acknowledgement with `cpl_vis` low leaves the read outstanding and keeps the unit blocked.
- R4: With `relaxed_mode` high, reads and writes issue back to back while earlier ones are outstanding, up to MAX_OUT (8) outstanding. With 8 outstanding, no further read or write issues until one completes.
- R5: In relaxed mode an acquire issues without waiting for earlier operations. After it issues, no later operation of any kind issues until every outstanding operation, the acquire included, has completed.
- R6: In relaxed mode a release issues only when no operation is outstanding. A read or write behind it issues while the release is still outstanding.
- R7: A fence, and any reserved kind code 5 to 7, issues only when nothing is outstanding. No later operation issues until it has completed.
- R8: A completion acknowledgement that arrives while nothing is outstanding has no effect. The next request in strict mode still issues at once.
- R9: After reset nothing is outstanding, `req_ready` is high and `mem_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| relaxed_mode | input | 1 | 0 strict sequential issue, 1 relaxed release-style issue |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may issue this cycle |
| req_kind | input | 3 | Operation kind code |
| req_tag | input | TAG_W | Request identifier |
| mem_valid | output | 1 | Operation issued to memory this cycle |
| mem_kind | output | 3 | Kind of the issued operation |
| mem_tag | output | TAG_W | Tag of the issued operation |
| cpl_valid | input | 1 | One outstanding operation has completed |
| cpl_vis | input | 1 | Completing read data is globally visible |

## Verification
A wrong outstanding count shows at the ports within a single cycle. A count that is too high stalls `req_ready` with nothing in flight, and the stall never clears. A count that is too low lets a strict-mode operation, or a ninth relaxed operation, issue while work is still outstanding, and this shows on the very next request. A stuck barrier or visibility flag shows up as a request that stays blocked past the acknowledgement that should free it. A flag that clears too early shows up as an issue that arrives a cycle or more ahead of that acknowledgement. The scoreboard therefore checks not only the order of the issued tags but also the cycles in which each request is held and then released.

// File: rtl/mo_pkg.sv
package mo_pkg;
  localparam int KIND_W = 3;
  typedef enum logic [KIND_W-1:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ACQ   = 3'd2,
    OP_REL   = 3'd3,
    OP_FENCE = 3'd4
  } op_kind_e;
endpackage

// File: rtl/mo_outst_ctr.sv
module mo_outst_ctr #(
  parameter int MAX_OUT = 8,
  localparam int CNT_W = $clog2(MAX_OUT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic inc,
  input  logic dec,
  output logic zero,
  output logic full
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dec_eff;
  logic             cnt_en;

  assign dec_eff = dec && (cnt_q != '0);
  assign cnt_en  = inc ^ dec_eff;

  always_comb begin
    cnt_d = cnt_q;
    if (inc && !dec_eff)      cnt_d = cnt_q + 1'b1;
    else if (!inc && dec_eff) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
  assign full = (cnt_q == CNT_W'(MAX_OUT));

  // R4
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_OUT));

  // R8
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero && dec && !inc) |=> zero);
endmodule

// File: rtl/mo_order_track.sv
module mo_order_track
  import mo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [KIND_W-1:0] fire_kind,
  input  logic              relaxed,
  input  logic              cnt_zero,
  input  logic              cpl_valid,
  input  logic              cpl_vis,
  output logic              hold,
  output logic              retire
);
  logic hold_q, hold_d;
  logic vis_wait_q, vis_wait_d;
  logic is_barrier;

  always_comb begin
    is_barrier = 1'b0;
    case (fire_kind)
      OP_READ, OP_WRITE, OP_REL: is_barrier = 1'b0;
      default:                   is_barrier = 1'b1;
    endcase
  end

  assign retire = cpl_valid && !(vis_wait_q && !cpl_vis);

  always_comb begin
    hold_d = hold_q;
    if (fire && is_barrier) hold_d = 1'b1;
    else if (cnt_zero)      hold_d = 1'b0;
    vis_wait_d = vis_wait_q;
    if (fire && !relaxed && (fire_kind == OP_READ)) vis_wait_d = 1'b1;
    else if (retire && !cnt_zero)                   vis_wait_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q     <= 1'b0;
      vis_wait_q <= 1'b0;
    end else begin
      hold_q     <= hold_d;
      vis_wait_q <= vis_wait_d;
    end
  end

  assign hold = hold_q && !cnt_zero;

  // R3
  vis_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vis_wait_q && cpl_valid && !cpl_vis && !fire) |=> !cnt_zero);
endmodule

// File: rtl/mo_issue_gate.sv
module mo_issue_gate
  import mo_pkg::*;
(
  input  logic              relaxed,
  input  logic [KIND_W-1:0] kind,
  input  logic              cnt_zero,
  input  logic              cnt_full,
  input  logic              hold,
  output logic              ok
);
  always_comb begin
    ok = cnt_zero;
    if (relaxed) begin
      case (kind)
        OP_READ, OP_WRITE, OP_ACQ: ok = !cnt_full && !hold;
        default:                   ok = cnt_zero;
      endcase
    end
  end
endmodule

// File: rtl/mo_issue_unit.sv
module mo_issue_unit
  import mo_pkg::*;
#(
  parameter int TAG_W   = 8,
  parameter int MAX_OUT = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              relaxed_mode,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [KIND_W-1:0] req_kind,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              mem_valid,
  output logic [KIND_W-1:0] mem_kind,
  output logic [TAG_W-1:0]  mem_tag,
  input  logic              cpl_valid,
  input  logic              cpl_vis
);
  logic cnt_zero, cnt_full, hold, retire;

  mo_issue_gate u_gate (
    .relaxed  (relaxed_mode),
    .kind     (req_kind),
    .cnt_zero (cnt_zero),
    .cnt_full (cnt_full),
    .hold     (hold),
    .ok       (req_ready)
  );

  assign mem_valid = req_valid && req_ready;
  assign mem_kind  = req_kind;
  assign mem_tag   = req_tag;

  mo_outst_ctr #(.MAX_OUT(MAX_OUT)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (mem_valid),
    .dec  (retire),
    .zero (cnt_zero),
    .full (cnt_full)
  );

  mo_order_track u_track (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (mem_valid),
    .fire_kind(req_kind),
    .relaxed  (relaxed_mode),
    .cnt_zero (cnt_zero),
    .cpl_valid(cpl_valid),
    .cpl_vis  (cpl_vis),
    .hold     (hold),
    .retire   (retire)
  );

  // R2
  sc_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !relaxed_mode) |=> !mem_valid);

  // R5
  acq_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && req_kind == OP_ACQ) |=> !mem_valid);

  // R6
  rel_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && relaxed_mode && req_kind == OP_REL) |-> cnt_zero);

  // R7
  fence_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && req_kind == OP_FENCE) |-> cnt_zero);
endmodule

// File: tb/tb_mo_issue_unit.sv
module tb_mo_issue_unit;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic relaxed_mode = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_kind = 3'd0;
  logic [TAG_W-1:0] req_tag = '0;
  logic mem_valid;
  logic [2:0] mem_kind;
  logic [TAG_W-1:0] mem_tag;
  logic cpl_valid = 1'b0;
  logic cpl_vis = 1'b0;

  int checks = 0;
  int failures = 0;
  int issued = 0;
  logic [TAG_W+2:0] exp_q[$];

  always #10 clk = ~clk;

  mo_issue_unit #(.TAG_W(TAG_W), .MAX_OUT(8)) dut (
    .clk(clk), .rst_n(rst_n), .relaxed_mode(relaxed_mode),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_tag(req_tag), .mem_valid(mem_valid), .mem_kind(mem_kind),
    .mem_tag(mem_tag), .cpl_valid(cpl_valid), .cpl_vis(cpl_vis)
  );

  task automatic chk(input bit ok, input string r, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // monitor: pops expected items in program order (R1)
  always @(negedge clk) begin
    if (rst_n && mem_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected issue", int'(mem_tag), -1);
      else begin
        logic [TAG_W+2:0] e;
        e = exp_q.pop_front();
        chk({mem_kind, mem_tag} == e, "R1 order/kind/tag", int'({mem_kind, mem_tag}), int'(e));
      end
      issued++;
    end
  end

  task automatic send(input logic [2:0] k, input logic [TAG_W-1:0] t);
    exp_q.push_back({k, t});
    @(posedge clk); #2;
    req_valid = 1'b1; req_kind = k; req_tag = t;
    forever begin
      @(negedge clk); #1;
      if (req_ready) break;
    end
    @(posedge clk); #2;
    req_valid = 1'b0;
  endtask

  task automatic ack(input bit vis);
    @(posedge clk); #2;
    cpl_valid = 1'b1; cpl_vis = vis;
    @(posedge clk); #2;
    cpl_valid = 1'b0; cpl_vis = 1'b0;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic ack_n(input int n);
    for (int i = 0; i < n; i++) ack(1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    cycles(1);
    // R9 reset state
    chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
    chk(mem_valid == 1'b0, "R9 no issue after reset", mem_valid, 0);

    // R8 spurious ack while idle, then strict write issues at once
    ack(1'b1);
    base = issued;
    send(3'd1, 8'h01);
    cycles(1);
    chk(issued == base + 1, "R8 issue after idle ack", issued, base + 1);

    // R2 strict: read waits for write completion
    fork send(3'd0, 8'h02); join_none
    cycles(5);
    chk(issued == base + 1, "R2 read held behind write", issued, base + 1);
    ack(1'b1);
    cycles(4);
    chk(issued == base + 2, "R2 read after write done", issued, base + 2);

    // R3 strict read needs visibility
    fork send(3'd1, 8'h03); join_none
    cycles(4);
    chk(issued == base + 2, "R2 write held behind read", issued, base + 2);
    ack(1'b0);
    cycles(4);
    chk(issued == base + 2, "R3 invisible ack keeps read open", issued, base + 2);
    ack(1'b1);
    cycles(4);
    chk(issued == base + 3, "R3 visible ack retires read", issued, base + 3);
    ack(1'b1);
    cycles(2);

    // R4 relaxed overlap up to 8
    relaxed_mode = 1'b1;
    base = issued;
    for (int i = 0; i < 8; i++) send(i[0] ? 3'd1 : 3'd0, 8'h10 + 8'(i));
    cycles(1);
    chk(issued == base + 8, "R4 eight overlapped", issued, base + 8);
    fork send(3'd0, 8'h18); join_none
    cycles(5);
    chk(issued == base + 8, "R4 ninth held at limit", issued, base + 8);
    ack(1'b1);
    cycles(4);
    chk(issued == base + 9, "R4 ninth after one ack", issued, base + 9);
    ack_n(8);
    cycles(2);

    // R5 acquire does not wait for earlier, blocks later
    base = issued;
    send(3'd1, 8'h20);
    send(3'd2, 8'h21);
    cycles(1);
    chk(issued == base + 2, "R5 acquire passes outstanding write", issued, base + 2);
    fork send(3'd0, 8'h22); join_none
    cycles(4);
    chk(issued == base + 2, "R5 read held behind acquire", issued, base + 2);
    ack(1'b1);
    cycles(4);
    chk(issued == base + 2, "R5 still held with acquire open", issued, base + 2);
    ack(1'b1);
    cycles(4);
    chk(issued == base + 3, "R5 read after all done", issued, base + 3);
    ack(1'b1);
    cycles(2);

    // R6 release waits for earlier, does not block later
    base = issued;
    send(3'd1, 8'h30);
    send(3'd1, 8'h31);
    fork send(3'd3, 8'h32); join_none
    cycles(4);
    chk(issued == base + 2, "R6 release held by writes", issued, base + 2);
    ack_n(2);
    cycles(4);
    chk(issued == base + 3, "R6 release after drain", issued, base + 3);
    send(3'd0, 8'h33);
    cycles(1);
    chk(issued == base + 4, "R6 read passes open release", issued, base + 4);
    ack_n(2);
    cycles(2);

    // R7 fence both ways
    base = issued;
    send(3'd0, 8'h40);
    fork send(3'd4, 8'h41); join_none
    cycles(4);
    chk(issued == base + 1, "R7 fence held by read", issued, base + 1);
    ack(1'b1);
    cycles(4);
    chk(issued == base + 2, "R7 fence after drain", issued, base + 2);
    fork send(3'd1, 8'h42); join_none
    cycles(4);
    chk(issued == base + 2, "R7 write held by fence", issued, base + 2);
    ack(1'b1);
    cycles(4);
    chk(issued == base + 3, "R7 write after fence done", issued, base + 3);
    ack(1'b1);
    cycles(2);

    chk(exp_q.size() == 0, "R1 all expected issued", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule